// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block holds the coherence state of one line in a private cache that sits on a shared snooping bus. It takes processor read, write and evict requests and the transactions it snoops from other caches. It decides which bus transaction to issue and computes the line's next state. It also drives the wired-OR shared and dirty responses, the memory-inhibit signal and the supply-data and write-back indications. A single elaboration parameter selects the state set. Value 0 gives a three-state invalidate protocol. Value 1 adds a clean exclusive state, value 2 adds a dirty owner state, and value 3 enables both.

A processor request that needs the bus raises a bus request and stalls with a busy output until the cycle in which a grant arrives. When several processor inputs are high together, write wins over read and read wins over evict. A snooped transaction is handled in the cycle it appears and takes precedence over any local request in that cycle. The local request then retries, and the transaction it needs is recomputed from the updated state. The tag lookup, the data array, arbitration and replacement are outside this block.

Top module: `coh_line_ctrl`

## Requirements
- R1: Line state codes are Invalid=0, Shared=1, Exclusive=2, Owner=3, Modified=4, and bus operation codes are Read=0, Write=1, Invalidate=2, WriteBack=3. A read to an Invalid line issues Read. With the exclusive state enabled the line fills to Exclusive if the shared input is low in the grant cycle and to Shared if it is high; without it, the line always fills to Shared.
- R2: A write to an Invalid line issues Write and ends in Modified. A write to a Shared or Owner line issues Invalidate and ends in Modified. A write to Exclusive moves to Modified with no bus request, and a write to Modified issues nothing.
- R3: A read to any valid line issues no bus request and leaves the state unchanged. A Shared line that snoops Read also stays Shared.
- R4: A valid line that snoops Read drives the shared output high; an Exclusive line also drops to Shared.
- R5: A Modified line that snoops Read drives supply-data. With the owner state enabled it moves to Owner with no write-back; without it, it raises write-back and moves to Shared. An Owner line that snoops Read supplies the data and stays Owner.
- R6: A Modified or Owner line that snoops Read or Write drives the dirty output and memory-inhibit.
- R7: A valid line that snoops Write or Invalidate moves to Invalid, and a Modified or Owner line that snoops Write also raises write-back. A snooped WriteBack changes nothing.
- R8: Evicting a Modified or Owner line issues WriteBack and ends in Invalid. Evicting a Shared or Exclusive line drops it to Invalid with no bus request.
- R9: Out of reset the line is Invalid and idle. A request that needs the bus holds busy and the bus request until the grant cycle, and the state does not move while it waits.
- R10: A snoop arriving in the same cycle as a local request is applied first and holds the request busy. The retried request uses the transaction that matches the new state.
- R11: A state that the chosen variant disables is never entered.
- R12: Of two controllers for the same line on one bus, at most one is in Modified, Exclusive or Owner at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_i | input | 1 | Processor read request, held until not busy |
| cpu_wr_i | input | 1 | Processor write request, held until not busy |
| cpu_evict_i | input | 1 | Replacement of this line, held until not busy |
| cpu_busy_o | output | 1 | Request stalled this cycle |
| bus_req_o | output | 1 | Line needs a bus transaction |
| bus_op_o | output | 2 | Transaction to issue when granted |
| bus_gnt_i | input | 1 | Grant; the transaction completes in this cycle |
| bus_shr_i | input | 1 | Wired-OR shared line seen during own transaction |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_op_i | input | 2 | Snooped transaction code |
| snp_shr_o | output | 1 | Shared response |
| snp_dirty_o | output | 1 | Dirty/owner response |
| snp_inhibit_o | output | 1 | Keep memory from answering |
| snp_supply_o | output | 1 | This line supplies data to the requester |
| snp_wback_o | output | 1 | This line must be written back now |
| line_state_o | output | 3 | Current line state |

## Verification
On every cycle, the assertions check the following. States disabled by the variant are never entered. A stalled request keeps the state still. A snooped Write always invalidates. A read miss fills to the state that the variant and the shared line select. An exclusive write completes silently, and a dirty eviction requests a write-back. The bench runs all four variants side by side on pairs of controllers sharing a modelled bus, and it compares every output against a behavioural model on every clock. Only these scenarios show how the two caches interact. They cover data supply versus write-back, an upgrade that becomes a full write after losing a race, and the rule that at most one cache owns the line.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_O = 3'd3,
      ST_M = 3'd4
   } line_st_t;

   typedef enum logic [1:0] {
      BOP_RD  = 2'd0,
      BOP_WR  = 2'd1,
      BOP_INV = 2'd2,
      BOP_WB  = 2'd3
   } bus_op_t;

   typedef enum logic [1:0] {
      LOC_NONE = 2'd0,
      LOC_RD   = 2'd1,
      LOC_WR   = 2'd2,
      LOC_EV   = 2'd3
   } loc_op_t;

   function automatic logic holds_dirty(line_st_t s);
      return (s == ST_M) || (s == ST_O);
   endfunction
endpackage

// File: rtl/coh_req_sel.sv
module coh_req_sel
   import coh_pkg::*;
(
   input  logic    rd_i,
   input  logic    wr_i,
   input  logic    ev_i,
   output loc_op_t op_o
);
   always_comb begin
      if (wr_i)      op_o = LOC_WR;
      else if (rd_i) op_o = LOC_RD;
      else if (ev_i) op_o = LOC_EV;
      else           op_o = LOC_NONE;
   end
endmodule

// File: rtl/coh_local_fsm.sv
module coh_local_fsm
   import coh_pkg::*;
#(
   parameter bit EN_EXCL = 1'b1
)(
   input  line_st_t state_i,
   input  loc_op_t  op_i,
   input  logic     shr_i,
   output logic     need_bus_o,
   output bus_op_t  bus_op_o,
   output line_st_t next_o
);
   line_st_t fill_st;

   generate
      if (EN_EXCL) begin : g_fill_excl
         assign fill_st = shr_i ? ST_S : ST_E;
      end else begin : g_fill_shared
         assign fill_st = ST_S;
      end
   endgenerate

   always_comb begin
      need_bus_o = 1'b0;
      bus_op_o   = BOP_RD;
      next_o     = state_i;
      unique case (op_i)
         LOC_RD: begin
            if (state_i == ST_I) begin
               need_bus_o = 1'b1;
               bus_op_o   = BOP_RD;
               next_o     = fill_st;
            end
         end
         LOC_WR: begin
            unique case (state_i)
               ST_I: begin
                  need_bus_o = 1'b1;
                  bus_op_o   = BOP_WR;
                  next_o     = ST_M;
               end
               ST_S, ST_O: begin
                  need_bus_o = 1'b1;
                  bus_op_o   = BOP_INV;
                  next_o     = ST_M;
               end
               default: next_o = ST_M;
            endcase
         end
         LOC_EV: begin
            if (holds_dirty(state_i)) begin
               need_bus_o = 1'b1;
               bus_op_o   = BOP_WB;
            end
            next_o = ST_I;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
   import coh_pkg::*;
#(
   parameter bit EN_OWN = 1'b1
)(
   input  line_st_t state_i,
   input  logic     valid_i,
   input  bus_op_t  op_i,
   output line_st_t next_o,
   output logic     shr_o,
   output logic     dirty_o,
   output logic     inhibit_o,
   output logic     supply_o,
   output logic     wback_o
);
   logic     hit;
   logic     dirty_hit;
   line_st_t mod_rd_st;
   logic     mod_rd_wb;

   assign hit       = valid_i && (state_i != ST_I);
   assign dirty_hit = valid_i && holds_dirty(state_i);

   generate
      if (EN_OWN) begin : g_keep_owner
         assign mod_rd_st = ST_O;
         assign mod_rd_wb = 1'b0;
      end else begin : g_flush_on_read
         assign mod_rd_st = ST_S;
         assign mod_rd_wb = 1'b1;
      end
   endgenerate

   always_comb begin
      next_o    = state_i;
      shr_o     = 1'b0;
      dirty_o   = 1'b0;
      inhibit_o = 1'b0;
      supply_o  = 1'b0;
      wback_o   = 1'b0;
      if (hit) begin
         unique case (op_i)
            BOP_RD: begin
               shr_o = 1'b1;
               if (dirty_hit) begin
                  dirty_o   = 1'b1;
                  inhibit_o = 1'b1;
                  supply_o  = 1'b1;
               end
               if (state_i == ST_E) next_o = ST_S;
               if (state_i == ST_M) begin
                  next_o  = mod_rd_st;
                  wback_o = mod_rd_wb;
               end
            end
            BOP_WR: begin
               if (dirty_hit) begin
                  dirty_o   = 1'b1;
                  inhibit_o = 1'b1;
                  wback_o   = 1'b1;
               end
               next_o = ST_I;
            end
            BOP_INV: next_o = ST_I;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter int unsigned PROTO = 3
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_rd_i,
   input  logic       cpu_wr_i,
   input  logic       cpu_evict_i,
   output logic       cpu_busy_o,
   output logic       bus_req_o,
   output logic [1:0] bus_op_o,
   input  logic       bus_gnt_i,
   input  logic       bus_shr_i,
   input  logic       snp_valid_i,
   input  logic [1:0] snp_op_i,
   output logic       snp_shr_o,
   output logic       snp_dirty_o,
   output logic       snp_inhibit_o,
   output logic       snp_supply_o,
   output logic       snp_wback_o,
   output logic [2:0] line_state_o
);
   localparam bit EN_EXCL = (PROTO % 2) == 1;
   localparam bit EN_OWN  = PROTO >= 2;

   generate
      if (PROTO > 3) begin : g_bad_proto
         initial $error("coh_line_ctrl: PROTO must be 0..3");
      end
   endgenerate

   line_st_t state_q, state_d;
   line_st_t loc_next, snp_next;
   loc_op_t  loc_op;
   bus_op_t  loc_bus_op;
   logic     loc_need;
   logic     req_act;
   logic     take_loc;

   coh_req_sel u_sel (
      .rd_i (cpu_rd_i),
      .wr_i (cpu_wr_i),
      .ev_i (cpu_evict_i),
      .op_o (loc_op)
   );

   coh_local_fsm #(.EN_EXCL(EN_EXCL)) u_local (
      .state_i    (state_q),
      .op_i       (loc_op),
      .shr_i      (bus_shr_i),
      .need_bus_o (loc_need),
      .bus_op_o   (loc_bus_op),
      .next_o     (loc_next)
   );

   coh_snoop_fsm #(.EN_OWN(EN_OWN)) u_snoop (
      .state_i   (state_q),
      .valid_i   (snp_valid_i),
      .op_i      (bus_op_t'(snp_op_i)),
      .next_o    (snp_next),
      .shr_o     (snp_shr_o),
      .dirty_o   (snp_dirty_o),
      .inhibit_o (snp_inhibit_o),
      .supply_o  (snp_supply_o),
      .wback_o   (snp_wback_o)
   );

   assign req_act    = (loc_op != LOC_NONE);
   assign bus_req_o  = req_act && loc_need;
   assign bus_op_o   = loc_bus_op;
   assign cpu_busy_o = req_act && (snp_valid_i || (loc_need && !bus_gnt_i));
   assign take_loc   = req_act && !cpu_busy_o;

   always_comb begin
      if (snp_valid_i)   state_d = snp_next;
      else if (take_loc) state_d = loc_next;
      else               state_d = state_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_I;
      else        state_q <= state_d;
   end

   assign line_state_o = state_q;

   AST_NO_EXCL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_E) || EN_EXCL); // R11
   AST_NO_OWNER_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_O) || EN_OWN); // R11
   AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_busy_o && !snp_valid_i |=> $stable(line_state_o)); // R9
   AST_SNOOP_WRITE_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid_i && snp_op_i == BOP_WR |=> line_state_o == ST_I); // R7
   AST_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid_i && bus_gnt_i && cpu_rd_i && !cpu_wr_i && line_state_o == ST_I
      |=> line_state_o == ((EN_EXCL && !$past(bus_shr_i)) ? ST_E : ST_S)); // R1
   AST_EXCL_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      line_state_o == ST_E && cpu_wr_i && !snp_valid_i
      |-> !bus_req_o ##1 line_state_o == ST_M); // R2
   AST_DIRTY_EVICT_WB: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_evict_i && !cpu_rd_i && !cpu_wr_i
      && (line_state_o == ST_M || line_state_o == ST_O)
      |-> bus_req_o && bus_op_o == BOP_WB); // R8
endmodule

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NINST = 8;
   localparam int K_RD = 1, K_WR = 2, K_EV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cpu_rd = '0, cpu_wr = '0, cpu_ev = '0, gnt_en = '0;
   logic cmp_on = 1'b0;

   logic       busy_w [NINST];
   logic       req_w  [NINST];
   logic [1:0] op_w   [NINST];
   logic       shr_w  [NINST];
   logic       dty_w  [NINST];
   logic       inh_w  [NINST];
   logic       sup_w  [NINST];
   logic       wb_w   [NINST];
   logic [2:0] st_w   [NINST];

   int    n_cmp = 0, n_bad = 0;
   int    mst [NINST];
   string cur_req = "R9 reset";

   always #(CLK_PERIOD / 2) clk = ~clk;

   for (genvar p = 0; p < 4; p++) begin : g_pair
      for (genvar c = 0; c < 2; c++) begin : g_cache
         localparam int K  = 2 * p + c;
         localparam int KO = 2 * p + (1 - c);
         coh_line_ctrl #(.PROTO(p)) i_coh_line_ctrl (
            .clk           (clk),
            .rst_n         (rst_n),
            .cpu_rd_i      (cpu_rd[c]),
            .cpu_wr_i      (cpu_wr[c]),
            .cpu_evict_i   (cpu_ev[c]),
            .cpu_busy_o    (busy_w[K]),
            .bus_req_o     (req_w[K]),
            .bus_op_o      (op_w[K]),
            .bus_gnt_i     (req_w[K] & gnt_en[c]),
            .bus_shr_i     (shr_w[KO]),
            .snp_valid_i   (req_w[KO] & gnt_en[1-c]),
            .snp_op_i      (op_w[KO]),
            .snp_shr_o     (shr_w[K]),
            .snp_dirty_o   (dty_w[K]),
            .snp_inhibit_o (inh_w[K]),
            .snp_supply_o  (sup_w[K]),
            .snp_wback_o   (wb_w[K]),
            .line_state_o  (st_w[K])
         );
      end
   end

   task automatic chk(int k, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s inst %0d %s: actual %0d expected %0d", cur_req, k, what, act, exp);
      end
   endtask

   // Behavioural reference: states I0 S1 E2 O3 M4, ops RD0 WR1 INV2 WB3.
   task automatic model_step();
      int lop[NINST], need[NINST], eop[NINST], lnx[NINST], egr[NINST];
      int sv[NINST], eshr[NINST], edty[NINST], esup[NINST], ewb[NINST], snx[NINST];
      for (int k = 0; k < NINST; k++) begin
         int c = k % 2;
         int p = k / 2;
         int s = mst[k];
         lop[k] = cpu_wr[c] ? K_WR : cpu_rd[c] ? K_RD : cpu_ev[c] ? K_EV : 0;
         need[k] = 0; eop[k] = 0; lnx[k] = s;
         if (lop[k] == K_RD && s == 0) begin need[k] = 1; eop[k] = 0; lnx[k] = -1; end
         if (lop[k] == K_WR) begin
            lnx[k] = 4;
            if (s == 0) begin need[k] = 1; eop[k] = 1; end
            else if (s == 1 || s == 3) begin need[k] = 1; eop[k] = 2; end
         end
         if (lop[k] == K_EV) begin
            lnx[k] = 0;
            if (s == 4 || s == 3) begin need[k] = 1; eop[k] = 3; end
         end
         egr[k] = (lop[k] != 0 && need[k] == 1 && gnt_en[c]) ? 1 : 0;
      end
      for (int k = 0; k < NINST; k++) begin
         int s = mst[k];
         int ko = k ^ 1;
         int own = (k / 2) >= 2;
         int sc = eop[ko];
         int dirty = (s == 4 || s == 3);
         sv[k] = egr[ko];
         eshr[k] = 0; edty[k] = 0; esup[k] = 0; ewb[k] = 0; snx[k] = s;
         if (sv[k] == 1 && s != 0) begin
            if (sc == 0) begin
               eshr[k] = 1;
               if (dirty) begin edty[k] = 1; esup[k] = 1; end
               if (s == 2) snx[k] = 1;
               if (s == 4) begin snx[k] = own ? 3 : 1; ewb[k] = own ? 0 : 1; end
            end else if (sc == 1) begin
               if (dirty) begin edty[k] = 1; ewb[k] = 1; end
               snx[k] = 0;
            end else if (sc == 2) snx[k] = 0;
         end
      end
      for (int k = 0; k < NINST; k++) begin
         int ereq = (lop[k] != 0 && need[k] == 1) ? 1 : 0;
         int ebusy = (lop[k] != 0 && (sv[k] == 1 || (need[k] == 1 && egr[k] == 0))) ? 1 : 0;
         int excl = (k / 2) % 2;
         int nxt;
         chk(k, "state", int'(st_w[k]), mst[k]);
         chk(k, "bus_req", int'(req_w[k]), ereq);
         if (ereq == 1) chk(k, "bus_op", int'(op_w[k]), eop[k]);
         chk(k, "busy", int'(busy_w[k]), ebusy);
         chk(k, "shared", int'(shr_w[k]), eshr[k]);
         chk(k, "dirty", int'(dty_w[k]), edty[k]);
         chk(k, "inhibit", int'(inh_w[k]), edty[k]);
         chk(k, "supply", int'(sup_w[k]), esup[k]);
         chk(k, "writeback", int'(wb_w[k]), ewb[k]);
         // R11: disabled states never visible
         chk(k, "R11 disabled state",
             ((st_w[k] == 3'd2 && excl == 0) || (st_w[k] == 3'd3 && (k / 2) < 2)) ? 1 : 0, 0);
         if (sv[k] == 1) nxt = snx[k];
         else if (lop[k] != 0 && ebusy == 0) begin
            nxt = lnx[k];
            if (nxt == -1) nxt = (excl == 1 && eshr[k ^ 1] == 0) ? 2 : 1;
         end else nxt = mst[k];
         mst[k] = nxt;
      end
      // R12: single owner per pair
      for (int p = 0; p < 4; p++) begin
         int owners = 0;
         for (int c = 0; c < 2; c++)
            if (st_w[2*p+c] >= 3'd2) owners++;
         chk(2 * p, "R12 owner count <= 1", (owners <= 1) ? 1 : 0, 1);
      end
   endtask

   always @(negedge clk) if (cmp_on) model_step();

   task automatic run(int c, int kind, int dly);
      @(posedge clk); #1;
      if (kind == K_RD) cpu_rd[c] = 1'b1;
      if (kind == K_WR) cpu_wr[c] = 1'b1;
      if (kind == K_EV) cpu_ev[c] = 1'b1;
      gnt_en[c] = (dly == 0);
      if (dly > 0) begin
         repeat (dly) @(posedge clk);
         #1 gnt_en[c] = 1'b1;
      end
      repeat (2) @(posedge clk);
      #1;
      cpu_rd = '0; cpu_wr = '0; cpu_ev = '0; gnt_en = '0;
      @(posedge clk);
   endtask

   initial begin
      for (int k = 0; k < NINST; k++) mst[k] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      @(posedge clk);
      cur_req = "R1 read miss fill";                   run(0, K_RD, 0);
      cur_req = "R4 snooped read marks shared";        run(1, K_RD, 0);
      cur_req = "R3 read hit stays quiet";             run(0, K_RD, 0);
      cur_req = "R9 stalled upgrade waits for grant";  run(0, K_WR, 3);
      cur_req = "R5 and R6 snooped read of dirty line"; run(1, K_RD, 0);
      cur_req = "R2 write to shared or owned line";    run(0, K_WR, 1);
      cur_req = "R7 snooped bus write";                run(1, K_WR, 0);
      cur_req = "R8 dirty eviction";                   run(1, K_EV, 0);
      cur_req = "R2 exclusive write";                  run(0, K_RD, 0);
      run(0, K_WR, 0);
      cur_req = "R5 second reader of dirty line";      run(1, K_RD, 0);
      // R10: both upgrade; B wins, A is snooped then retries as a full write
      cur_req = "R10 snoop beats stalled request";
      @(posedge clk); #1;
      cpu_wr = 2'b11; gnt_en = 2'b10;
      repeat (2) @(posedge clk);
      #1 cpu_wr[1] = 1'b0; gnt_en = 2'b00;
      @(posedge clk);
      #1 gnt_en = 2'b01;
      repeat (2) @(posedge clk);
      #1 cpu_wr = '0; gnt_en = '0;
      @(posedge clk);
      cur_req = "R7 snooped write-back ignored";       run(0, K_EV, 0);
      cur_req = "R8 clean eviction";                   run(0, K_RD, 0);
      run(0, K_EV, 0);
      repeat (2) @(posedge clk);
      cmp_on = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule